// File: doc/BRIEF.md
# Command-Word Sampling Controller

This block sits between a host register port and an external analog-to-digital converter. The host writes one 16-bit command word. The word names the channel to convert, gives a mask of multiplexer inputs to enable, and may ask for a settling pause. The block then sequences exactly one conversion. It asserts a one-cycle trigger toward the converter and holds the channel controls steady until the converter reports that it has finished.

When the sample comes back, its top bit is inverted. This turns the converter's offset-binary code into two's complement. The block stores the result in a readable register and sets a sticky completion flag in a status register. The host clears that flag by writing a one to the same bit. An enable register gates the flag onto an interrupt line.

There are ten multiplexer inputs. The two highest-numbered inputs are internal reference sources. A start request that arrives while a conversion is in flight is dropped.

Top module: `adcc_ctrl`

## Requirements
- R1: After a synchronous reset, all four readable registers read 0, `irq` is 0 and `conv_start` is 0. The register addresses are: 0 command, 1 interrupt enable, 2 status, 3 result.
- R2: The block accepts a command-register write with bit 0 set while it is idle. In the cycle after that write, `conv_start` pulses high for one cycle. `conv_chan` shows word bits 4:1 and `conv_mux_en` shows word bits 14:5, and both hold until completion. Reading address 0 returns the accepted word.
- R3: A command-register write with bit 0 clear starts nothing: no `conv_start`, the busy flag stays clear, and address 0 keeps its old value.
- R4: When the accepted word has bit 15 set, `conv_start` comes SETTLE_CYCLES clock cycles later than it would without the delay.
- R5: A start command written while a conversion is busy is ignored: it adds no trigger and changes neither the channel outputs nor the stored command.
- R6: Status bit 0 reads 1 from the cycle after acceptance until the converter's `conv_done` is seen, and reads 0 afterwards.
- R7: Status bit 2 is set when `conv_done` is seen during a conversion. It stays set until cleared. If a set and a clear happen in the same cycle, the set wins.
- R8: A status write with bit 2 at 1 clears the completion flag. A status write with bit 2 at 0 leaves it unchanged.
- R9: The result register captures `conv_data` XOR 0x8000 in the cycle `conv_done` is seen, and keeps that value until the next completion.
- R10: `irq` equals the completion flag ANDed with bit 2 of the enable register, one clock later. The enable register reads back only bit 2.
- R11: `host_rdata` is registered. It shows the register selected by `host_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data |
| conv_start | output | 1 | One-cycle converter trigger |
| conv_chan | output | 4 | Channel index to convert |
| conv_mux_en | output | 10 | Multiplexer input enable mask |
| conv_done | input | 1 | Converter finished, data valid |
| conv_data | input | 16 | Converter sample, offset binary |
| irq | output | 1 | Completion interrupt |

## Verification
The bench goes after these corner cases:
- **Second start during a settling pause.** A design that re-armed on it would emit two triggers or switch channels mid-conversion.
- **Start bit clear.** A design that ignored the start bit would launch conversions on configuration writes.
- **Exact trigger latency, with and without the settling pause.** This exposes off-by-one errors in the delay counter.
- **Clear write landing in the same cycle as completion.** A design giving the clear priority would lose the event.
- **Clear write with bit 2 at zero.** A design that cleared on any status write would drop the flag.
- **Randomized samples spanning the sign boundary.** A missing or misplaced MSB inversion shows up in the result.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
  localparam int unsigned WORD_W = 16;

  // register addresses
  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_IEN  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_RES  = 2'd3;

  // status / enable bit positions
  localparam int unsigned S_BUSY = 0;
  localparam int unsigned S_DONE = 2;

  // result coding
  localparam logic [WORD_W-1:0] SIGN_FLIP = 16'h8000;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_CONV   = 2'd2
  } sq_state_t;

  // field layout of the command word (bit positions are behaviour)
  typedef struct packed {
    logic       settle;  // [15]
    logic [9:0] mask;    // [14:5]
    logic [3:0] idx;     // [4:1]
    logic       go;      // [0]
  } cmd_word_t;
endpackage

// File: rtl/adcc_cmd_decode.sv
module adcc_cmd_decode
  import adcc_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [WORD_W-1:0] word,
  input  logic              wr,
  input  logic [1:0]        addr,
  output logic              go_req,
  output logic              settle,
  output logic [IDX_W-1:0]  idx,
  output logic [NUM_CH-1:0] mask
);
  cmd_word_t cw;

  always_comb begin
    cw     = cmd_word_t'(word);
    go_req = wr && (addr == A_CMD) && cw.go;
    settle = cw.settle;
    idx    = cw.idx;
    mask   = cw.mask;
  end
endmodule

// File: rtl/adcc_sequencer.sv
module adcc_sequencer
  import adcc_pkg::*;
#(
  parameter int unsigned NUM_CH        = 10,
  parameter int unsigned IDX_W         = 4,
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_req,
  input  logic              settle,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NUM_CH-1:0] mask,
  input  logic [WORD_W-1:0] word,
  input  logic              conv_done,
  input  logic [WORD_W-1:0] conv_data,
  output logic              conv_start,
  output logic [IDX_W-1:0]  conv_chan,
  output logic [NUM_CH-1:0] conv_mux_en,
  output logic              busy,
  output logic              complete,
  output logic [WORD_W-1:0] result_q,
  output logic [WORD_W-1:0] cmd_q
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  sq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic            accept;

  assign accept   = go_req && (state == SQ_IDLE);
  assign complete = (state == SQ_CONV) && conv_done;
  assign busy     = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      cnt         <= '0;
      conv_start  <= 1'b0;
      conv_chan   <= '0;
      conv_mux_en <= '0;
      result_q    <= '0;
      cmd_q       <= '0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (accept) begin
            conv_chan   <= idx;
            conv_mux_en <= mask;
            cmd_q       <= word;
            if (settle) begin
              state <= SQ_SETTLE;
              cnt   <= CNT_LOAD;
            end else begin
              state      <= SQ_CONV;
              conv_start <= 1'b1;
            end
          end
        end
        SQ_SETTLE: begin
          if (cnt == '0) begin
            state      <= SQ_CONV;
            conv_start <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_CONV: begin
          if (conv_done) begin
            result_q <= conv_data ^ SIGN_FLIP;
            state    <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // checker state: length of the settling window and delay flag of the
  // conversion in flight
  logic [CNT_W:0] win_cnt;
  logic           was_delayed;
  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt     <= '0;
      was_delayed <= 1'b0;
    end else if (accept) begin
      win_cnt     <= '0;
      was_delayed <= settle;
    end else if (state == SQ_SETTLE) begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  assert_settle_len_R4: assert property (@(posedge clk) disable iff (rst)
    (conv_start && was_delayed) |-> (win_cnt == (CNT_W+1)'(SETTLE_CYCLES)));

  assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (rst)
    (go_req && busy) |=> ($stable(conv_chan) && $stable(conv_mux_en) && $stable(cmd_q) && !conv_start)
      || $past(state == SQ_SETTLE));

  assert_result_flip_R9: assert property (@(posedge clk) disable iff (rst)
    complete |=> (result_q == ($past(conv_data) ^ SIGN_FLIP)));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !complete |=> $stable(result_q));
endmodule

// File: rtl/adcc_status.sv
module adcc_status
  import adcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              complete,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              done_q,
  output logic              ien_q,
  output logic              irq
);
  logic clr_req;
  assign clr_req = wr && (addr == A_STAT) && wdata[S_DONE];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ien_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (complete)     done_q <= 1'b1;
      else if (clr_req) done_q <= 1'b0;
      if (wr && (addr == A_IEN)) ien_q <= wdata[S_DONE];
      irq <= done_q && ien_q;
    end
  end

  assert_done_set_R7: assert property (@(posedge clk) disable iff (rst)
    complete |=> done_q);

  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !complete) |=> !done_q);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    (!complete && !clr_req) |=> $stable(done_q));

  assert_irq_on_R10: assert property (@(posedge clk) disable iff (rst)
    (done_q && ien_q) |=> irq);

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (rst)
    !(done_q && ien_q) |=> !irq);
endmodule

// File: rtl/adcc_ctrl.sv
module adcc_ctrl
  import adcc_pkg::*;
#(
  parameter int unsigned NUM_CH        = 10,
  parameter int unsigned IDX_W         = 4,
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_wr,
  input  logic [1:0]             host_addr,
  input  logic [WORD_W-1:0]      host_wdata,
  output logic [WORD_W-1:0]      host_rdata,
  output logic                   conv_start,
  output logic [IDX_W-1:0]       conv_chan,
  output logic [NUM_CH-1:0]      conv_mux_en,
  input  logic                   conv_done,
  input  logic [WORD_W-1:0]      conv_data,
  output logic                   irq
);
  logic              go_req, settle, busy, complete, done_q, ien_q;
  logic [IDX_W-1:0]  idx;
  logic [NUM_CH-1:0] mask;
  logic [WORD_W-1:0] result_q, cmd_q, stat_w, ien_w;

  adcc_cmd_decode #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dec (
    .word(host_wdata), .wr(host_wr), .addr(host_addr),
    .go_req(go_req), .settle(settle), .idx(idx), .mask(mask)
  );

  adcc_sequencer #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .go_req(go_req), .settle(settle), .idx(idx),
    .mask(mask), .word(host_wdata), .conv_done(conv_done),
    .conv_data(conv_data), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_mux_en(conv_mux_en), .busy(busy), .complete(complete),
    .result_q(result_q), .cmd_q(cmd_q)
  );

  adcc_status u_stat (
    .clk(clk), .rst(rst), .complete(complete), .wr(host_wr),
    .addr(host_addr), .wdata(host_wdata), .done_q(done_q),
    .ien_q(ien_q), .irq(irq)
  );

  always_comb begin
    stat_w         = '0;
    stat_w[S_BUSY] = busy;
    stat_w[S_DONE] = done_q;
    ien_w          = '0;
    ien_w[S_DONE]  = ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      case (host_addr)
        A_CMD:   host_rdata <= cmd_q;
        A_IEN:   host_rdata <= ien_w;
        A_STAT:  host_rdata <= stat_w;
        default: host_rdata <= result_q;
      endcase
    end
  end

  assert_rdata_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(host_addr) == A_RES && $past(!complete)) |-> host_rdata == result_q);

  assert_busy_clear_R6: assert property (@(posedge clk) disable iff (rst)
    complete |=> !stat_w[S_BUSY]);
endmodule

// File: tb/sim_adcc_ctrl.sv
`timescale 1ns/1ps
module sim_adcc_ctrl;
  localparam int SETTLE = 6;
  localparam int LAT    = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic [9:0]  conv_mux_en;
  logic        conv_done;
  logic [15:0] conv_data;
  logic        irq;

  logic        stub_auto = 1'b1;
  logic        stub_done;
  logic        man_done = 1'b0;
  logic [15:0] stub_val = '0;
  int          lat_cnt;
  int          cyc;
  int          start_cnt;
  int          start_cyc;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  assign conv_done = stub_done | man_done;
  assign conv_data = stub_val;

  always #2 clk = ~clk;

  adcc_ctrl #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_mux_en(conv_mux_en), .conv_done(conv_done),
    .conv_data(conv_data), .irq(irq)
  );

  // cycle counter, trigger monitor and converter stub
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      lat_cnt   <= 0;
      stub_done <= 1'b0;
      start_cnt <= 0;
      start_cyc <= 0;
    end else begin
      stub_done <= 1'b0;
      if (conv_start) begin
        start_cnt <= start_cnt + 1;
        start_cyc <= cyc;
      end
      if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) stub_done <= 1'b1;
      end else if (conv_start && stub_auto) begin
        lat_cnt <= LAT;
      end
    end
  end
  initial cyc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d, output int c0);
    host_wr = 1'b1; host_addr = a; host_wdata = d; c0 = cyc;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 200; i++) begin
      rd_reg(2'd2, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [15:0] mk_cmd(input bit dly, input logic [9:0] m,
                                          input logic [3:0] ch, input bit go);
    return {dly, m, ch, go};
  endfunction

  task automatic run_conv(input string tag, input bit dly, input logic [9:0] m,
                          input logic [3:0] ch, input logic [15:0] sv);
    int c0; int n0; logic [15:0] r;
    stub_val = sv;
    n0 = start_cnt;
    wr_reg(2'd0, mk_cmd(dly, m, ch, 1'b1), c0);
    for (int i = 0; i < SETTLE + 4; i++) @(negedge clk);
    chk({tag, " R2 one trigger"}, start_cnt - n0, 1);
    chk({tag, dly ? " R4 latency" : " R2 latency"}, start_cyc - c0, dly ? 1 + SETTLE : 1);
    chk({tag, " R2 chan"}, conv_chan, ch);
    chk({tag, " R2 mask"}, conv_mux_en, m);
    wait_idle();
    rd_reg(2'd3, r);
    chk({tag, " R9 result"}, r, sv ^ 16'h8000);
  endtask

  initial begin
    logic [15:0] r;
    int c0; int n0;
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int c0; int n0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 conv_start", conv_start, 0);
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], r);
      chk("R1 reg zero", r, 0);
    end

    // R2 / R9 no delay, R6 busy visible
    stub_val = 16'h0123;
    wr_reg(2'd0, mk_cmd(0, 10'h004, 4'd2, 1), c0);
    rd_reg(2'd2, r);
    chk("R6 busy set", r[0], 1);
    wait_idle();
    rd_reg(2'd2, r);
    chk("R6 busy clear", r[0], 0);
    chk("R7 done set", r[2], 1);
    rd_reg(2'd3, r);
    chk("R9 result", r, 16'h8123);
    rd_reg(2'd0, r);
    chk("R2 cmd readback", r, mk_cmd(0, 10'h004, 4'd2, 1));

    // R10 irq gated by enable
    chk("R10 irq off while disabled", irq, 0);
    wr_reg(2'd1, 16'hFFFF, c0);
    @(negedge clk);
    chk("R10 irq on", irq, 1);
    rd_reg(2'd1, r);
    chk("R10 enable readback", r, 16'h0004);

    // R8 write-one-to-clear
    wr_reg(2'd2, 16'hFFFB, c0);
    rd_reg(2'd2, r);
    chk("R8 zero write keeps flag", r[2], 1);
    wr_reg(2'd2, 16'h0004, c0);
    rd_reg(2'd2, r);
    chk("R8 w1c clears flag", r[2], 0);
    @(negedge clk);
    chk("R10 irq drops", irq, 0);

    // R3 start bit clear
    n0 = start_cnt;
    wr_reg(2'd0, mk_cmd(1, 10'h3FF, 4'd9, 0), c0);
    repeat (SETTLE + 4) @(negedge clk);
    chk("R3 no trigger", start_cnt - n0, 0);
    rd_reg(2'd2, r);
    chk("R3 not busy", r[0], 0);
    rd_reg(2'd0, r);
    chk("R3 cmd unchanged", r, mk_cmd(0, 10'h004, 4'd2, 1));

    // R4 delayed conversion
    run_conv("delay", 1, 10'h300, 4'd8, 16'h7FFF);

    // R5 start while busy (during settle)
    stub_val = 16'h8000;
    n0 = start_cnt;
    wr_reg(2'd0, mk_cmd(1, 10'h001, 4'd0, 1), c0);
    wr_reg(2'd0, mk_cmd(0, 10'h200, 4'd9, 1), c0);
    repeat (SETTLE + 3) @(negedge clk);
    wr_reg(2'd0, mk_cmd(0, 10'h100, 4'd8, 1), c0);
    chk("R5 chan kept", conv_chan, 0);
    chk("R5 mask kept", conv_mux_en, 10'h001);
    wait_idle();
    chk("R5 single trigger", start_cnt - n0, 1);
    rd_reg(2'd0, r);
    chk("R5 cmd kept", r, mk_cmd(1, 10'h001, 4'd0, 1));
    rd_reg(2'd3, r);
    chk("R9 zero code", r, 16'h0000);

    // R7 set wins over simultaneous clear
    stub_auto = 1'b0;
    stub_val  = 16'h1234;
    wr_reg(2'd0, mk_cmd(0, 10'h010, 4'd4, 1), c0);
    host_wr = 1'b1; host_addr = 2'd2; host_wdata = 16'h0004; man_done = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; man_done = 1'b0;
    rd_reg(2'd2, r);
    chk("R7 set beats clear", r[2], 1);
    chk("R6 idle after done", r[0], 0);
    rd_reg(2'd3, r);
    chk("R9 manual result", r, 16'h9234);
    stub_auto = 1'b1;
    wr_reg(2'd2, 16'h0004, c0);

    // R11 registered read path: address change shows one clock later
    host_addr = 2'd1;
    @(negedge clk);
    host_addr = 2'd3;
    chk("R11 old addr before edge", host_rdata, 16'h0004);
    @(negedge clk);
    chk("R11 new addr after edge", host_rdata, 16'h9234);

    // random mix
    for (int k = 0; k < 24; k++) begin
      run_conv("rand", 1'($urandom), 10'($urandom), 4'($urandom_range(0, 9)),
               16'($urandom));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule